// File: doc/BRIEF.md
# Synchronized PWM Output Steering Unit

This block takes one pulse-width-modulated waveform, made by a small internal period/duty counter, and routes it to any mix of four output pins, A to D. A pin whose steering bit is set carries the waveform. A pin whose bit is clear carries its general-purpose port data bit. The polarity of the waveform is set separately for the pair A/C and the pair B/D. Steering only happens when the mode register selects single-output operation. In every other mode, all four pins carry port data.

A host programs four registers through a simple write strobe: the period, the duty, the mode, and the steering word. The steering word holds the 4-bit pin mask and a commit-mode bit. In immediate mode, a new mask takes effect on the clock edge that performs the write, even if a pulse is then cut short on a pin. In deferred mode, the mask is held in a shadow and applied on the counter wrap that starts the next period, so each pin gains or loses only whole PWM cycles. The write port is a plain control interface with no back-pressure: every strobed write is accepted on the edge where it is sampled.

Top module: `pwm_steer_unit`

## Requirements
- R1: The counter runs 0..period and the raw waveform is high while count < duty. A pin whose active mask bit is set (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D) outputs that waveform while single-output mode is selected.
- R2: Single-output mode means mode bits [5:4] = 00 and mode bits [3:2] = 11. In any other mode, every pin outputs its port data bit.
- R3: Mode bit 1 = 1 inverts the steered waveform on A and C, and mode bit 0 = 1 inverts it on B and D. Port data reaching a non-steered pin is never inverted.
- R4: A steering write with bit 4 = 0 loads the active mask on the same clock edge and cancels any held mask.
- R5: A steering write with bit 4 = 1 leaves the active mask unchanged until the next counter wrap (count >= period), where the held mask becomes active. In this mode every high pulse on an active-high pin with port data 0 lasts exactly duty cycles.
- R6: Several deferred writes within one period apply only the last written mask at the wrap. A deferred write on the wrap edge itself waits for the following wrap.
- R7: Reset clears the count, period, duty, mode, the active mask and the held mask, so all pins show port data.
- R8: With the active mask all zero, no pin carries the waveform and every pin equals its port data bit.
- R9: The write addresses are 0 = period, 1 = duty, 2 = mode (bits [5:0]), 3 = steering (bits [3:0] mask, bit 4 commit mode). Each write takes effect on the edge where it is sampled.
- R10: The counter wraps to 0 on any cycle where count >= period, so a period shortened below the current count ends the period on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| port_data | input | 4 | General-purpose data per pin, bit 0 = A |
| pin_out | output | 4 | Pin values, bit 0 = A |

## Verification
The assertions assume that rst_n is held low for at least one edge before any check, and that the write inputs only change away from the active edge. The bench drives every input on the falling edge and holds reset for several cycles. The pulse-length check for deferred mode assumes that duty stays at or below period and that the mode and duty do not change during that phase. The bench keeps them fixed while it moves the mask at different offsets within a period.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 6;
  localparam logic [ADDR_W-1:0] REG_PERIOD = 2'd0;
  localparam logic [ADDR_W-1:0] REG_DUTY   = 2'd1;
  localparam logic [ADDR_W-1:0] REG_MODE   = 2'd2;
  localparam logic [ADDR_W-1:0] REG_STEER  = 2'd3;

  typedef struct packed {
    logic [1:0] bridge;
    logic [1:0] pwm_hi;
    logic       pol_ac;
    logic       pol_bd;
  } mode_t;

  function automatic logic is_single(input mode_t m);
    return (m.bridge == 2'b00) && (m.pwm_hi == 2'b11);
  endfunction
endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs
  import pwm_steer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PINS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] period_q,
  output logic [DATA_W-1:0] duty_q,
  output mode_t             mode_q,
  output logic              steer_wr,
  output logic [PINS-1:0]   steer_mask,
  output logic              steer_sync
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      duty_q   <= '0;
      mode_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_PERIOD: period_q <= wr_data;
        REG_DUTY:   duty_q   <= wr_data;
        REG_MODE:   mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
        default:    ;
      endcase
    end
  end

  always_comb begin
    steer_wr   = wr_en && (wr_addr == REG_STEER);
    steer_mask = wr_data[PINS-1:0];
    steer_sync = wr_data[PINS];
  end

  assert_period_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_PERIOD) |=> (period_q == $past(wr_data)));
  assert_duty_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_DUTY) |=> (duty_q == $past(wr_data)));
endmodule

// File: rtl/pwm_steer_timebase.sv
module pwm_steer_timebase #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] period_q,
  input  logic [DATA_W-1:0] duty_q,
  output logic              wrap,
  output logic              pwm_raw
);
  logic [DATA_W-1:0] cnt;

  always_comb begin
    wrap    = (cnt >= period_q);
    pwm_raw = (cnt < duty_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assert_wrap_to_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  assert_count_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_steer_shadow.sv
module pwm_steer_shadow #(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrap,
  input  logic            steer_wr,
  input  logic [PINS-1:0] steer_mask,
  input  logic            steer_sync,
  output logic [PINS-1:0] active
);
  logic [PINS-1:0] pending;
  logic            pend_v;
  logic            now_wr;
  logic            held_wr;

  always_comb begin
    now_wr  = steer_wr && !steer_sync;
    held_wr = steer_wr && steer_sync;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= '0;
      pending <= '0;
      pend_v  <= 1'b0;
    end else begin
      if (now_wr)                active <= steer_mask;
      else if (wrap && pend_v)   active <= pending;

      if (held_wr)               pending <= steer_mask;

      if (held_wr)               pend_v <= 1'b1;
      else if (now_wr || wrap)   pend_v <= 1'b0;
    end
  end

  assert_immediate_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    now_wr |=> (active == $past(steer_mask)));
  assert_hold_until_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!now_wr && !(wrap && pend_v)) |=> $stable(active));
  assert_commit_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!now_wr && wrap && pend_v) |=> (active == $past(pending)));
  assert_last_write_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    held_wr |=> (pend_v && pending == $past(steer_mask)));
endmodule

// File: rtl/pwm_steer_pinmux.sv
module pwm_steer_pinmux
  import pwm_steer_pkg::*;
#(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mode_t           mode_q,
  input  logic            pwm_raw,
  input  logic [PINS-1:0] active,
  input  logic [PINS-1:0] port_data,
  output logic [PINS-1:0] pin_out
);
  logic single;

  always_comb single = is_single(mode_q);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic inv;
    if (i % 2 == 0) begin : g_ac
      always_comb inv = mode_q.pol_ac;
    end else begin : g_bd
      always_comb inv = mode_q.pol_bd;
    end
    always_comb pin_out[i] = (single && active[i]) ? (pwm_raw ^ inv) : port_data[i];
  end

  assert_other_mode_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !single |-> (pin_out == port_data));
  assert_empty_mask_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (pin_out == port_data));
endmodule

// File: rtl/pwm_steer_unit.sv
module pwm_steer_unit
  import pwm_steer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PINS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PINS-1:0]   port_data,
  output logic [PINS-1:0]   pin_out
);
  logic [DATA_W-1:0] period_q;
  logic [DATA_W-1:0] duty_q;
  mode_t             mode_q;
  logic              steer_wr;
  logic [PINS-1:0]   steer_mask;
  logic              steer_sync;
  logic              wrap;
  logic              pwm_raw;
  logic [PINS-1:0]   active;

  pwm_steer_regs #(.DATA_W(DATA_W), .PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period_q(period_q), .duty_q(duty_q), .mode_q(mode_q),
    .steer_wr(steer_wr), .steer_mask(steer_mask), .steer_sync(steer_sync));

  pwm_steer_timebase #(.DATA_W(DATA_W)) u_time (
    .clk(clk), .rst_n(rst_n), .period_q(period_q), .duty_q(duty_q),
    .wrap(wrap), .pwm_raw(pwm_raw));

  pwm_steer_shadow #(.PINS(PINS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .steer_wr(steer_wr),
    .steer_mask(steer_mask), .steer_sync(steer_sync), .active(active));

  pwm_steer_pinmux #(.PINS(PINS)) u_mux (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .pwm_raw(pwm_raw),
    .active(active), .port_data(port_data), .pin_out(pin_out));

  assert_reset_port_R7: assert property (@(posedge clk)
    !rst_n |=> (pin_out == port_data));
endmodule

// File: tb/pwm_steer_unit_test.sv
module pwm_steer_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] port_data = '0;
  logic [3:0] pin_out;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit run_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R7";

  int m_cnt = 0, m_period = 0, m_duty = 0, m_mode = 0, m_active = 0;
  int held[$];
  int run_len[4];

  always #2.5 clk = ~clk;

  pwm_steer_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_data(port_data), .pin_out(pin_out));

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin : model
    bit wrp;
    if (!rst_n) begin
      m_cnt = 0; m_period = 0; m_duty = 0; m_mode = 0; m_active = 0;
      held.delete();
    end else begin
      wrp = (m_cnt >= m_period);
      m_cnt = wrp ? 0 : m_cnt + 1;
      if (wrp && held.size() > 0) begin
        m_active = held[$];
        held.delete();
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_period = int'(wr_data);
          2'd1: m_duty = int'(wr_data);
          2'd2: m_mode = int'(wr_data) & 63;
          default: begin
            if (wr_data[4]) held.push_back(int'(wr_data) & 15);
            else begin
              m_active = int'(wr_data) & 15;
              held.delete();
            end
          end
        endcase
      end
    end
  end

  function automatic logic [3:0] expect_pins();
    logic [3:0] r;
    bit single, pwm, inv;
    single = (((m_mode >> 4) & 3) == 0) && (((m_mode >> 2) & 3) == 3);
    pwm = (m_cnt < m_duty);
    for (int i = 0; i < 4; i++) begin
      inv = (i % 2 == 0) ? m_mode[1] : m_mode[0];
      r[i] = (single && m_active[i]) ? (pwm ^ inv) : port_data[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pin_out actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // compare shortly after every rising edge
  always @(posedge clk) begin
    #1;
    if (cmp_on) check(cur_req, pin_out, expect_pins());
    if (run_on) begin
      for (int i = 0; i < 4; i++) begin
        if (pin_out[i]) run_len[i]++;
        else begin
          if (run_len[i] != 0) begin
            checks++;
            if (run_len[i] != m_duty) begin
              fails++;
              $display("FAIL R5 pin %0d pulse length actual=%0d expected=%0d", i, run_len[i], m_duty);
            end
          end
          run_len[i] = 0;
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    port_data = 4'b1010;
    idle(4);
    check("R7", pin_out, 4'b1010);                // reset: port data on every pin
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(3);

    cur_req = "R9";
    wr(2'd0, 8'd9);
    wr(2'd1, 8'd4);
    wr(2'd2, 8'h0C);                               // single mode, both pairs active-high
    cur_req = "R8";
    idle(12);                                      // mask still zero
    port_data = 4'b0101;
    idle(4);

    cur_req = "R4";
    port_data = 4'b0000;
    wr(2'd3, 8'h01);                               // immediate, A only
    idle(7);
    wr(2'd3, 8'h0A);                               // immediate mid-period, B and D
    idle(5);
    wr(2'd3, 8'h0F);
    cur_req = "R1";
    idle(25);

    cur_req = "R3";
    port_data = 4'b0110;
    wr(2'd3, 8'h05);                               // A and C steered, B and D port data
    wr(2'd2, 8'h0E);                               // invert A/C
    idle(22);
    wr(2'd3, 8'h0A);
    wr(2'd2, 8'h0D);                               // invert B/D
    idle(22);

    cur_req = "R2";
    wr(2'd3, 8'h0F);
    wr(2'd2, 8'h1C);                               // bridge field non-zero
    idle(15);
    wr(2'd2, 8'h08);                               // PWM bits not 11
    idle(15);
    wr(2'd2, 8'h0C);

    cur_req = "R5";
    port_data = 4'b0000;
    wr(2'd3, 8'h00);
    idle(10);
    run_on = 1'b1;
    for (int k = 0; k < 12; k++) begin
      wr(2'd3, 8'h10 | 8'((k * 5) & 15));          // deferred mask change at a moving offset
      idle(3 + (k % 7));
    end
    cur_req = "R6";
    for (int k = 0; k < 6; k++) begin
      wr(2'd3, 8'h13);
      wr(2'd3, 8'h1C);                             // last one in the period wins
      idle(10 + k);
    end
    idle(12);
    run_on = 1'b0;

    cur_req = "R4";
    wr(2'd3, 8'h1F);
    wr(2'd3, 8'h02);                               // immediate write cancels held mask
    idle(25);

    cur_req = "R10";
    wr(2'd0, 8'd40);
    wr(2'd3, 8'h0F);
    idle(25);
    wr(2'd0, 8'd3);                                // shorten below current count
    idle(20);

    cur_req = "R8";
    wr(2'd3, 8'h00);
    port_data = 4'b1100;
    idle(10);

    cmp_on = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule